// File: doc/BRIEF.md
# Fixed Off-Time PWM Current Chopper

This block regulates the current in one H-bridge winding. It drives the four gate enables of the bridge. An on phase turns on one diagonal pair, a high-side switch on one leg and a low-side switch on the other, and the phase polarity picks which pair. Current then builds in the winding until the external sense comparator signals that the DAC threshold has been reached. At that point the on phase ends and a fixed off period of programmable length starts. During the off period the current decays in slow, fast or mixed fashion. When the off period expires, a new on phase begins.

In mixed decay the off period is split in two. The first part, of programmable length, is fast decay and the rest is slow decay. Every change of the gate pattern restarts a blanking window, and a comparator trip seen inside that window is dropped. A change of polarity passes through a short dead interval in which all four gates are off. Any disable condition forces every gate off at once: enable deasserted, sleep, a thermal fault or undervoltage. Undervoltage also raises a reset request toward the step translator. A zero DAC magnitude never starts an on phase.

All lengths are counts of clock cycles, supplied by registers outside this block.

Top module: `pwm_chopper`

## Requirements
- R1: During an on phase, polarity 0 drives gate vector {hs_a,ls_a,hs_b,ls_b} = 1001 and polarity 1 drives 0110.
- R2: A trip accepted in an on phase ends it at the next clock edge. With trip held high, each on phase lasts blank_len+1 cycles.
- R3: The off period lasts off_len cycles, where off_len = 0 is treated as 1. After it, an on phase starts again if the DAC magnitude is nonzero.
- R4: Slow decay (mode 00) keeps only the low-side switch of the active diagonal on during the off period: 0001 for polarity 0, 0100 for polarity 1.
- R5: Fast decay (mode 01) turns all four gates off for the whole off period.
- R6: Mixed decay (mode 10, and mode 11 likewise) turns all gates off for the first min(fast_len, off_len) cycles of the off period, then uses the slow-decay pattern.
- R7: A trip that falls inside the blanking window, which lasts blank_len cycles after any gate change, is discarded and has no later effect.
- R8: When en_ni is high, or sleep_i, therm_flt_i or uv_flt_i is high, all gates are off in that same cycle.
- R9: xlat_rst_o is high exactly while uv_flt_i is high.
- R10: A zero DAC magnitude starts no on phase. If the magnitude drops to zero during an on phase, the bridge goes to the slow-decay pattern and stays there.
- R11: A polarity change while any gate is active gives DEAD_CYC cycles (3 by default) with all gates off before the opposite diagonal turns on. The two diagonals are never active in adjacent cycles.
- R12: While rst_ni is low, all gates are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_ni | input | 1 | Output enable, active low |
| sleep_i | input | 1 | Sleep request, forces gates off |
| therm_flt_i | input | 1 | Thermal fault flag |
| uv_flt_i | input | 1 | Undervoltage flag |
| polarity_i | input | 1 | Winding current direction |
| dac_mag_i | input | DAC_W | Current threshold magnitude; zero means no drive |
| decay_mode_i | input | 2 | 00 slow, 01 fast, 10/11 mixed |
| trip_i | input | 1 | Synchronised sense comparator output |
| off_len_i | input | CNT_W | Fixed off period in cycles |
| blank_len_i | input | CNT_W | Blanking window in cycles |
| fast_len_i | input | CNT_W | Fast-decay part of a mixed off period |
| hs_a_o | output | 1 | High-side gate, leg A |
| ls_a_o | output | 1 | Low-side gate, leg A |
| hs_b_o | output | 1 | High-side gate, leg B |
| ls_b_o | output | 1 | Low-side gate, leg B |
| xlat_rst_o | output | 1 | Translator reset request |

## Verification
The assertions assume that trip_i is already synchronous to clk_i. They also assume that a high-side turn-off is explained by the preceding cycle's inputs alone, that is, the length registers and the decay mode are not rewritten while a period is in flight. The stimulus changes every input on the falling edge. It reprograms lengths, mode and polarity only while the bridge is held disabled, except in the directed polarity-change and blanking cases. The sweep covers every combination of small off, fast and blank lengths, every mode and both polarities, and compares two full periods against arithmetic predictions.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ON,
    ST_OFF,
    ST_HOLD,
    ST_DEAD
  } chop_st_e;

  typedef enum logic [1:0] {
    DK_SLOW  = 2'b00,
    DK_FAST  = 2'b01,
    DK_MIXED = 2'b10,
    DK_MIX2  = 2'b11
  } decay_e;

  typedef struct packed {
    logic hs_a;
    logic ls_a;
    logic hs_b;
    logic ls_b;
  } gates_t;
endpackage

// File: rtl/chop_blank_ctr.sv
module chop_blank_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             open_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= len_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign open_o = (cnt_q == '0);
endmodule

// File: rtl/chop_gate_dec.sv
module chop_gate_dec
  import chop_pkg::*;
(
  input  chop_st_e st_i,
  input  logic     pol_i,
  input  logic     fast_i,
  output gates_t   gates_o
);
  gates_t drive, slow;

  // diagonal pair and its low-side-only recirculation pattern
  always_comb begin
    drive = pol_i ? gates_t'(4'b0110) : gates_t'(4'b1001);
    slow  = pol_i ? gates_t'(4'b0100) : gates_t'(4'b0001);
  end

  always_comb begin
    unique case (st_i)
      ST_ON:   gates_o = drive;
      ST_OFF:  gates_o = fast_i ? gates_t'(4'b0000) : slow;
      ST_HOLD: gates_o = slow;
      default: gates_o = gates_t'(4'b0000);
    endcase
  end
endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper
  import chop_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int DAC_W    = 4,
  parameter int DEAD_CYC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_ni,
  input  logic             sleep_i,
  input  logic             therm_flt_i,
  input  logic             uv_flt_i,
  input  logic             polarity_i,
  input  logic [DAC_W-1:0] dac_mag_i,
  input  logic [1:0]       decay_mode_i,
  input  logic             trip_i,
  input  logic [CNT_W-1:0] off_len_i,
  input  logic [CNT_W-1:0] blank_len_i,
  input  logic [CNT_W-1:0] fast_len_i,
  output logic             hs_a_o,
  output logic             ls_a_o,
  output logic             hs_b_o,
  output logic             ls_b_o,
  output logic             xlat_rst_o
);
  localparam logic [CNT_W-1:0] DEAD_LAST = CNT_W'(DEAD_CYC - 1);

  chop_st_e         st_q, st_n;
  logic             pol_q, pol_n;
  logic [CNT_W-1:0] tmr_q, tmr_n;
  decay_e           mode_q, mode_n;
  gates_t           gate_q, gate_n;

  logic             kill, dac_nz, blank_open, trip_acc, pol_chg, fast_ph, mixed_n;
  logic [CNT_W-1:0] off_eff, fast_eff, off_last;

  assign kill     = en_ni | sleep_i | therm_flt_i | uv_flt_i;
  assign dac_nz   = (dac_mag_i != '0);
  assign pol_chg  = (polarity_i != pol_q);
  assign trip_acc = (st_q == ST_ON) && blank_open && trip_i;

  // zero off length behaves as one; fast part never outlasts the period
  assign off_eff  = (off_len_i == '0) ? CNT_W'(1) : off_len_i;
  assign fast_eff = (fast_len_i > off_eff) ? off_eff : fast_len_i;
  assign off_last = off_eff - 1'b1;

  always_comb begin
    st_n   = st_q;
    pol_n  = pol_q;
    tmr_n  = tmr_q;
    mode_n = mode_q;
    if (kill) begin
      st_n  = ST_IDLE;
      tmr_n = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (dac_nz) begin
            st_n  = ST_ON;
            pol_n = polarity_i;
          end
        end
        ST_ON: begin
          if (pol_chg) begin
            st_n  = ST_DEAD;
            tmr_n = '0;
          end else if (!dac_nz) begin
            st_n = ST_HOLD;
          end else if (trip_acc) begin
            st_n   = ST_OFF;
            tmr_n  = '0;
            mode_n = decay_e'(decay_mode_i);
          end
        end
        ST_OFF: begin
          if (pol_chg) begin
            st_n  = ST_DEAD;
            tmr_n = '0;
          end else if (tmr_q >= off_last) begin
            st_n  = dac_nz ? ST_ON : ST_HOLD;
            tmr_n = '0;
          end else begin
            tmr_n = tmr_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (pol_chg) begin
            st_n  = ST_DEAD;
            tmr_n = '0;
          end else if (dac_nz) begin
            st_n = ST_ON;
          end
        end
        ST_DEAD: begin
          if (tmr_q >= DEAD_LAST) begin
            st_n  = dac_nz ? ST_ON : ST_IDLE;
            pol_n = polarity_i;
            tmr_n = '0;
          end else begin
            tmr_n = tmr_q + 1'b1;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  assign mixed_n = (mode_n == DK_MIXED) || (mode_n == DK_MIX2);
  assign fast_ph = (st_n == ST_OFF) &&
                   ((mode_n == DK_FAST) || (mixed_n && (tmr_n < fast_eff)));

  chop_gate_dec i_gate_dec (
    .st_i    (st_n),
    .pol_i   (pol_n),
    .fast_i  (fast_ph),
    .gates_o (gate_n)
  );

  chop_blank_ctr #(.CNT_W(CNT_W)) i_blank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (gate_n != gate_q),
    .len_i  (blank_len_i),
    .open_o (blank_open)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pol_q  <= 1'b0;
      tmr_q  <= '0;
      mode_q <= DK_SLOW;
      gate_q <= gates_t'(4'b0000);
    end else begin
      st_q   <= st_n;
      pol_q  <= pol_n;
      tmr_q  <= tmr_n;
      mode_q <= mode_n;
      gate_q <= gate_n;
    end
  end

  assign hs_a_o     = gate_q.hs_a & ~kill;
  assign ls_a_o     = gate_q.ls_a & ~kill;
  assign hs_b_o     = gate_q.hs_b & ~kill;
  assign ls_b_o     = gate_q.ls_b & ~kill;
  assign xlat_rst_o = uv_flt_i;
endmodule

// File: rtl/chop_chk.sv
module chop_chk #(
  parameter int DAC_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_ni,
  input logic             sleep_i,
  input logic             therm_flt_i,
  input logic             uv_flt_i,
  input logic             polarity_i,
  input logic [DAC_W-1:0] dac_mag_i,
  input logic             trip_i,
  input logic             hs_a_o,
  input logic             ls_a_o,
  input logic             hs_b_o,
  input logic             ls_b_o
);
  logic kill;
  assign kill = en_ni | sleep_i | therm_flt_i | uv_flt_i;

  // R11
  diag_ab_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_a_o || ls_b_o) |=> !(hs_b_o || ls_a_o));

  // R11
  diag_ba_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_b_o || ls_a_o) |=> !(hs_a_o || ls_b_o));

  // R8
  kill_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill |-> !(hs_a_o || ls_a_o || hs_b_o || ls_b_o));

  // R10
  zero_dac_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_mag_i == '0) |=> !(hs_a_o || hs_b_o));

  // R2
  on_end_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hs_a_o || hs_b_o) && !kill) |->
      ($past(trip_i) || $past(kill) || ($past(dac_mag_i) == '0) ||
       ($past(polarity_i) != $past(hs_b_o))));
endmodule

bind pwm_chopper chop_chk #(.DAC_W(DAC_W)) i_chop_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_ni       (en_ni),
  .sleep_i     (sleep_i),
  .therm_flt_i (therm_flt_i),
  .uv_flt_i    (uv_flt_i),
  .polarity_i  (polarity_i),
  .dac_mag_i   (dac_mag_i),
  .trip_i      (trip_i),
  .hs_a_o      (hs_a_o),
  .ls_a_o      (ls_a_o),
  .hs_b_o      (hs_b_o),
  .ls_b_o      (ls_b_o)
);

// File: tb/test_pwm_chopper.sv
module test_pwm_chopper;
  localparam int CNT_W = 8;
  localparam int DAC_W = 4;
  localparam int DEAD  = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en_ni = 1'b1, sleep_i = 1'b0, therm_i = 1'b0, uv_i = 1'b0;
  logic pol = 1'b0, trip = 1'b0;
  logic [DAC_W-1:0] dac = '0;
  logic [1:0] mode = 2'b00;
  logic [CNT_W-1:0] off_len = 8'd3, blank_len = 8'd0, fast_len = 8'd0;
  logic hs_a, ls_a, hs_b, ls_b, xrst;
  logic [3:0] g;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_chopper #(.CNT_W(CNT_W), .DAC_W(DAC_W), .DEAD_CYC(DEAD)) i_pwm_chopper (
    .clk_i(clk), .rst_ni(rst_ni), .en_ni(en_ni), .sleep_i(sleep_i),
    .therm_flt_i(therm_i), .uv_flt_i(uv_i), .polarity_i(pol),
    .dac_mag_i(dac), .decay_mode_i(mode), .trip_i(trip),
    .off_len_i(off_len), .blank_len_i(blank_len), .fast_len_i(fast_len),
    .hs_a_o(hs_a), .ls_a_o(ls_a), .hs_b_o(hs_b), .ls_b_o(ls_b),
    .xlat_rst_o(xrst));

  assign g = {hs_a, ls_a, hs_b, ls_b};

  task automatic chk(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_pat(input int i, input int off, input int fst,
                                         input int blk, input int md, input bit p);
    int oe, fe, per, ph, q;
    logic [3:0] on, sl;
    oe  = (off == 0) ? 1 : off;
    fe  = (fst > oe) ? oe : fst;
    per = blk + 1 + oe;
    ph  = i % per;
    on  = p ? 4'b0110 : 4'b1001;
    sl  = p ? 4'b0100 : 4'b0001;
    if (ph < blk + 1) return on;
    q = ph - blk - 1;
    if (md == 0) return sl;
    if (md == 1) return 4'b0000;
    return (q < fe) ? 4'b0000 : sl;
  endfunction

  task automatic park();
    en_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic sweep_one(input int off, input int fst, input int blk, input int md, input bit p);
    bit bad = 0;
    logic [3:0] a0 = '0, e0 = '0;
    park();
    trip = 1'b1; dac = 4'd5; pol = p; mode = md[1:0];
    off_len = off[CNT_W-1:0]; fast_len = fst[CNT_W-1:0]; blank_len = blk[CNT_W-1:0];
    @(negedge clk);
    en_ni = 1'b0;
    for (int i = 0; i < 2 * (blk + 2 + off) + 1; i++) begin
      @(negedge clk);
      if (!bad && g != exp_pat(i, off, fst, blk, md, p)) begin
        bad = 1; a0 = g; e0 = exp_pat(i, off, fst, blk, md, p);
      end
    end
    // R1 R2 R3 R4 R5 R6
    chk(!bad, $sformatf("R1/R2/R3 R4 R5 R6 sweep off=%0d fast=%0d blank=%0d mode=%0d pol=%0d",
        off, fst, blk, md, p), a0, e0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    dac = 4'd5;
    en_ni = 1'b0;
    repeat (3) @(negedge clk);
    // R12
    chk(g == 4'b0000, "R12 reset gates", g, 4'b0000);
    rst_ni = 1'b1;
    park();

    for (int md = 0; md < 4; md++)
      for (int p = 0; p < 2; p++)
        for (int off = 0; off < 5; off++)
          for (int fst = 0; fst < 6; fst++)
            for (int blk = 0; blk < 3; blk++)
              sweep_one(off, fst, blk, md, p[0]);

    // R7: trip pulse inside blanking is dropped
    park();
    trip = 1'b0; dac = 4'd5; pol = 1'b0; mode = 2'b00; off_len = 8'd3; blank_len = 8'd4;
    @(negedge clk); en_ni = 1'b0;
    @(negedge clk); @(negedge clk);
    trip = 1'b1;
    @(negedge clk);
    trip = 1'b0;
    begin
      bit bad = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (g != 4'b1001) bad = 1;
      end
      chk(!bad, "R7 blanked trip discarded", g, 4'b1001);
    end
    trip = 1'b1;
    @(negedge clk);
    chk(g == 4'b0001, "R7 trip after blank accepted", g, 4'b0001);
    trip = 1'b0;

    // R8 R9: each disable source forces gates off in the same cycle
    for (int s = 0; s < 4; s++) begin
      park();
      trip = 1'b0; pol = 1'b1; blank_len = 8'd0;
      @(negedge clk); en_ni = 1'b0;
      @(negedge clk); @(negedge clk);
      chk(g == 4'b0110, "R1 on before disable", g, 4'b0110);
      case (s)
        0: en_ni = 1'b1;
        1: sleep_i = 1'b1;
        2: therm_i = 1'b1;
        default: uv_i = 1'b1;
      endcase
      #1;
      chk(g == 4'b0000, $sformatf("R8 disable source %0d", s), g, 4'b0000);
      chk(xrst == (s == 3), $sformatf("R9 translator reset source %0d", s),
          {3'b000, xrst}, {3'b000, (s == 3)});
      @(negedge clk);
      sleep_i = 1'b0; therm_i = 1'b0; uv_i = 1'b0;
    end

    // R10: zero magnitude from idle, then drop to zero mid on phase
    park();
    dac = 4'd0; trip = 1'b0; pol = 1'b0; blank_len = 8'd0;
    @(negedge clk); en_ni = 1'b0;
    begin
      bit bad = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (g != 4'b0000) bad = 1;
      end
      chk(!bad, "R10 zero dac idle", g, 4'b0000);
    end
    dac = 4'd7;
    @(negedge clk); @(negedge clk);
    chk(g == 4'b1001, "R10 on with nonzero dac", g, 4'b1001);
    dac = 4'd0;
    begin
      bit bad = 0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (g != 4'b0001) bad = 1;
      end
      chk(!bad, "R10 hold slow decay at zero dac", g, 4'b0001);
    end

    // R11: polarity flip inserts dead cycles
    dac = 4'd7;
    @(negedge clk);
    chk(g == 4'b1001, "R11 on pol0", g, 4'b1001);
    pol = 1'b1;
    begin
      bit bad = 0;
      for (int i = 0; i < DEAD; i++) begin
        @(negedge clk);
        if (g != 4'b0000) bad = 1;
      end
      chk(!bad, "R11 dead cycles", g, 4'b0000);
    end
    @(negedge clk);
    chk(g == 4'b0110, "R11 opposite diagonal after dead", g, 4'b0110);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule